// File: doc/BRIEF.md
# Register-File String Move Engine

The engine copies a run of bytes between memory and a 32-entry, 32-bit register file. One start command sets the direction, the transfer kind, the first register, the byte count and the base address. The engine then works through the run one memory access at a time. Each access is a word or a byte, and each waits on a request/acknowledge handshake. Loaded data goes into the register file through a write port. Stored data is read through a read port with a combinational read path.

There are two transfer kinds. A multi-register transfer moves one word per register, from the first register up to register 31. A string transfer moves any number of bytes. It moves whole words while more than three bytes remain. It then handles the remaining one to three bytes one at a time, packed big-endian into a single register. During a string transfer the register index rolls from 31 back to 0. The engine raises a one-cycle done pulse when it finishes. The byte-count width is the parameter `CNT_W` and must be at least 8, so that a full multi-register run of 128 bytes fits.

Top module: `rf_strmove`

## Requirements
- R1: While reset is held and after its release, `busy_o`, `mem_req_o`, `rf_we_o` and `done_o` are all low.
- R2: A multi-register load (`xfer_store_i`=0, `xfer_string_i`=0) fills register k, for each k from the first register through 31, with the big-endian word at base + 4·(k − first register). The word's lowest-addressed byte goes to bits 31:24. The byte count is ignored in this mode.
- R3: A multi-register store (`xfer_store_i`=1, `xfer_string_i`=0) writes each register, from the first through 31, as a big-endian word at base + 4·(k − first register). No other memory byte changes.
- R4: In string mode, while more than three bytes remain, each access is a word access (`mem_byte_o`=0). The next access is at the address plus 4 and uses the next register.
- R5: In string mode the register index that follows 31 is 0.
- R6: A string load places the one to three trailing bytes in one register. The first byte goes to bits 31:24, the second to 23:16 and the third to 15:8, and the unfilled low bytes are zero. A byte read returns its data in `mem_rdata_i[7:0]`.
- R7: A string store sends the trailing bytes from one register, starting at bits 31:24 and moving down. Each byte goes to the next byte address (`mem_byte_o`=1) in `mem_wdata_o[7:0]`.
- R8: A string command with a byte count of zero makes no memory request and no register write. It raises `done_o` in the cycle after the start.
- R9: While a request is not acknowledged, the request, address, size, direction and write data stay unchanged.
- R10: A start that arrives while the engine is busy, or in its done cycle, is ignored. The running transfer ends with the same result it would have had without it.
- R11: `done_o` is high for exactly one cycle, in the cycle after the last acknowledge. No request is active in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command strobe |
| xfer_store_i | input | 1 | 1 = store registers to memory, 0 = load |
| xfer_string_i | input | 1 | 1 = string (byte count), 0 = multi-register |
| first_reg_i | input | 5 | First register of the run |
| byte_cnt_i | input | CNT_W | Byte count for string mode |
| base_addr_i | input | ADDR_W | Byte address of the first access |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (store) |
| mem_byte_o | output | 1 | 1 = byte access, 0 = word access |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 32 | Write data (byte in bits 7:0) |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| rf_raddr_o | output | 5 | Register read index |
| rf_rdata_i | input | 32 | Register read data (combinational) |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 32 | Register write data |

## Verification
The write-data stability property assumes that `rf_rdata_i` stays constant during a store. That holds because nothing else writes the register file while the engine runs. The bench keeps this condition by changing its register and memory models only from the engine's own write strobes between commands. The address-step properties assume that the memory acknowledges only an active request. The bench raises `mem_ack_i` only while `mem_req_o` is high, with a varying stall of zero to three cycles. Start pulses sent during a transfer, including the done cycle, are used on purpose to probe the ignore rule.

// File: rtl/strmove_pkg.sv
package strmove_pkg;

    localparam int unsigned REG_COUNT  = 32;
    localparam int unsigned REG_IDX_W  = $clog2(REG_COUNT);
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned WORD_BYTES = WORD_W / 8;
    localparam int unsigned LANE_W     = $clog2(WORD_BYTES);

    typedef logic [REG_IDX_W-1:0] reg_idx_t;
    typedef logic [LANE_W-1:0]    lane_t;
    typedef logic [WORD_W-1:0]    word_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_XFER = 1'b1
    } seq_state_e;

    // Register cursor: which register and which byte lane within it.
    typedef struct packed {
        reg_idx_t idx;
        lane_t    lane;
    } rf_cursor_t;

    // Shift that puts lane 0 at bits 31:24, lane 1 at 23:16, and so on.
    function automatic logic [4:0] lane_shift(input lane_t l);
        return {~l, 3'b000};
    endfunction

    function automatic word_t lane_merge(input word_t acc, input logic [7:0] b,
                                         input lane_t l);
        return acc | (word_t'(b) << lane_shift(l));
    endfunction

    function automatic logic [7:0] lane_pick(input word_t w, input lane_t l);
        word_t s;
        s = w >> lane_shift(l);
        return s[7:0];
    endfunction

endpackage

// File: rtl/strmove_step.sv
module strmove_step
    import strmove_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  rem_i,
    input  rf_cursor_t        cur_i,
    output logic              is_word_o,
    output logic              lane_full_o,
    output logic              last_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  rem_o,
    output rf_cursor_t        cur_o
);
    localparam logic [CNT_W-1:0]  WORD_CNT  = CNT_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);
    localparam lane_t             LANE_TOP  = lane_t'(WORD_BYTES - 1);

    always_comb begin
        is_word_o   = rem_i > CNT_W'(WORD_BYTES - 1);
        lane_full_o = !is_word_o && (cur_i.lane == LANE_TOP);
        if (is_word_o) begin
            addr_o   = addr_i + WORD_STEP;
            rem_o    = rem_i - WORD_CNT;
            cur_o.idx  = cur_i.idx + 1'b1;   // natural wrap 31 -> 0
            cur_o.lane = '0;
        end else begin
            addr_o     = addr_i + 1'b1;
            rem_o      = rem_i - 1'b1;
            cur_o.lane = cur_i.lane + 1'b1;
            cur_o.idx  = lane_full_o ? cur_i.idx + 1'b1 : cur_i.idx;
        end
        last_o = (rem_o == '0);
    end

endmodule

// File: rtl/strmove_lane.sv
module strmove_lane
    import strmove_pkg::*;
(
    input  logic  is_word_i,
    input  lane_t lane_i,
    input  word_t acc_i,
    input  word_t mem_rdata_i,
    input  word_t rf_rdata_i,
    output word_t rf_wdata_o,
    output word_t mem_wdata_o,
    output word_t acc_o
);
    word_t merged;

    always_comb begin
        merged = lane_merge(acc_i, mem_rdata_i[7:0], lane_i);
        if (is_word_i) begin
            rf_wdata_o  = mem_rdata_i;
            mem_wdata_o = rf_rdata_i;
        end else begin
            rf_wdata_o  = merged;
            mem_wdata_o = word_t'(lane_pick(rf_rdata_i, lane_i));
        end
        acc_o = merged;
    end

endmodule

// File: rtl/rf_strmove.sv
module rf_strmove
    import strmove_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              xfer_store_i,
    input  logic              xfer_string_i,
    input  logic [4:0]        first_reg_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_byte_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic [4:0]        rf_raddr_o,
    input  logic [31:0]       rf_rdata_i,
    output logic              rf_we_o,
    output logic [4:0]        rf_waddr_o,
    output logic [31:0]       rf_wdata_o
);
    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    rf_cursor_t        cur_q;
    word_t             acc_q;
    logic              store_q;
    logic              done_q;

    logic [CNT_W-1:0]  multi_cnt, first_cnt;
    logic              is_word, lane_full, step_last, ack_now;
    logic [ADDR_W-1:0] step_addr;
    logic [CNT_W-1:0]  step_rem;
    rf_cursor_t        step_cur;
    word_t             acc_next;

    // A multi-register run is a string run of whole words ending at register 31.
    assign multi_cnt = CNT_W'((int'(REG_COUNT) - int'(first_reg_i)) * int'(WORD_BYTES));
    assign first_cnt = xfer_string_i ? byte_cnt_i : multi_cnt;
    assign ack_now   = (state_q == SEQ_XFER) && mem_ack_i;

    strmove_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_step (
        .addr_i      (addr_q),
        .rem_i       (rem_q),
        .cur_i       (cur_q),
        .is_word_o   (is_word),
        .lane_full_o (lane_full),
        .last_o      (step_last),
        .addr_o      (step_addr),
        .rem_o       (step_rem),
        .cur_o       (step_cur)
    );

    strmove_lane i_lane (
        .is_word_i   (is_word),
        .lane_i      (cur_q.lane),
        .acc_i       (acc_q),
        .mem_rdata_i (mem_rdata_i),
        .rf_rdata_i  (rf_rdata_i),
        .rf_wdata_o  (rf_wdata_o),
        .mem_wdata_o (mem_wdata_o),
        .acc_o       (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            cur_q   <= '0;
            acc_q   <= '0;
            store_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i && !done_q) begin
                        if (first_cnt == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q    <= SEQ_XFER;
                            addr_q     <= base_addr_i;
                            rem_q      <= first_cnt;
                            cur_q.idx  <= first_reg_i;
                            cur_q.lane <= '0;
                            acc_q      <= '0;
                            store_q    <= xfer_store_i;
                        end
                    end
                end
                SEQ_XFER: begin
                    if (mem_ack_i) begin
                        addr_q <= step_addr;
                        rem_q  <= step_rem;
                        cur_q  <= step_cur;
                        if (!store_q && !is_word)
                            acc_q <= lane_full ? '0 : acc_next;
                        if (step_last) begin
                            state_q <= SEQ_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy_o     = (state_q == SEQ_XFER);
    assign done_o     = done_q;
    assign mem_req_o  = busy_o;
    assign mem_we_o   = busy_o && store_q;
    assign mem_byte_o = busy_o && !is_word;
    assign mem_addr_o = addr_q;
    assign rf_raddr_o = cur_q.idx;
    assign rf_waddr_o = cur_q.idx;
    assign rf_we_o    = ack_now && !store_q && (is_word || step_last || lane_full);

endmodule

// File: rtl/strmove_chk.sv
module strmove_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic              mem_byte_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [31:0]       mem_wdata_o,
    input logic              mem_ack_i,
    input logic              rf_we_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_byte_o)
                                    && $stable(mem_we_o) && $stable(mem_wdata_o)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R11
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_req_o && !busy_o); // R11
    AST_RF_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> mem_req_o && mem_ack_i && !mem_we_o); // R6
    AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_ack_i && !mem_byte_o |=>
            !mem_req_o || (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4))); // R4
    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_ack_i && mem_byte_o |=>
            !mem_req_o || (mem_byte_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R7
endmodule

bind rf_strmove strmove_chk #(.ADDR_W(ADDR_W)) i_strmove_chk (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_byte_o  (mem_byte_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .rf_we_o     (rf_we_o)
);

// File: tb/test_rf_strmove.sv
module test_rf_strmove;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic start_i = 1'b0, xfer_store_i = 1'b0, xfer_string_i = 1'b0;
    logic [4:0] first_reg_i = '0;
    logic [CNT_W-1:0] byte_cnt_i = '0;
    logic [ADDR_W-1:0] base_addr_i = '0;
    logic busy_o, done_o, mem_req_o, mem_we_o, mem_byte_o, rf_we_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [31:0] mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o;
    logic mem_ack_i = 1'b0;
    logic [4:0] rf_raddr_o, rf_waddr_o;

    logic [7:0]  mem [256];
    logic [31:0] rf  [32];
    logic [7:0]  exp_mem [256];
    logic [31:0] exp_rf  [32];

    int checks = 0, fails = 0, req_cycles = 0, stall_seed = 0, wait_cnt = 0;
    logic prev_stall = 1'b0;
    logic [ADDR_W-1:0] prev_addr;
    logic prev_byte, prev_we;
    logic [31:0] prev_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    rf_strmove #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_rf_strmove (
        .clk(clk), .rst(rst), .start_i(start_i), .xfer_store_i(xfer_store_i),
        .xfer_string_i(xfer_string_i), .first_reg_i(first_reg_i), .byte_cnt_i(byte_cnt_i),
        .base_addr_i(base_addr_i), .busy_o(busy_o), .done_o(done_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_byte_o(mem_byte_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory model: big-endian words, byte data in bits 7:0.
    always_comb begin
        logic [7:0] a;
        a = mem_addr_o[7:0];
        if (mem_byte_o) mem_rdata_i = {24'h0, mem[a]};
        else mem_rdata_i = {mem[a], mem[8'(a+1)], mem[8'(a+2)], mem[8'(a+3)]};
        rf_rdata_i = rf[rf_raddr_o];
    end

    always @(posedge clk) begin
        if (!rst && mem_req_o && mem_ack_i && mem_we_o) begin
            if (mem_byte_o) mem[mem_addr_o[7:0]] <= mem_wdata_o[7:0];
            else for (int k = 0; k < 4; k++)
                mem[8'(mem_addr_o[7:0] + k)] <= mem_wdata_o[31-8*k -: 8];
        end
        if (!rst && rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
    end

    // Acknowledge with a varying stall; check that a stalled request holds (R9).
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall)
                check(mem_req_o && mem_addr_o == prev_addr && mem_byte_o == prev_byte &&
                      mem_we_o == prev_we && mem_wdata_o == prev_wdata,
                      "R9 request held", mem_addr_o, prev_addr);
            if (mem_req_o) req_cycles++;
            if (mem_req_o && wait_cnt == 0) begin
                mem_ack_i = 1'b1;
                stall_seed = stall_seed + 1;
                wait_cnt = (stall_seed * 5) % 4;
            end else begin
                mem_ack_i = 1'b0;
                if (mem_req_o) wait_cnt = wait_cnt - 1;
            end
            prev_stall = mem_req_o && !mem_ack_i;
            prev_addr = mem_addr_o; prev_byte = mem_byte_o;
            prev_we = mem_we_o; prev_wdata = mem_wdata_o;
        end
    end

    task automatic preload(input int seed);
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + seed * 13 + 3);
        for (int r = 0; r < 32; r++) rf[r] = {8'hA0 + 8'(seed), 8'(r), 8'(r * 3 + seed), 8'(~r)};
    endtask

    // Behavioural reference of the requirement rules.
    task automatic model(input bit st, input bit sm, input int sreg, input int cnt, input int base);
        int r, n, a, sh;
        logic [31:0] tmp;
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        for (int i = 0; i < 32; i++) exp_rf[i] = rf[i];
        r = sreg; a = base;
        n = sm ? cnt : (32 - sreg) * 4;
        while (n > 3) begin
            if (r == 32) r = 0;
            for (int k = 0; k < 4; k++)
                if (st) exp_mem[(a + k) % 256] = exp_rf[r][31-8*k -: 8];
                else exp_rf[r][31-8*k -: 8] = exp_mem[(a + k) % 256];
            r++; a += 4; n -= 4;
        end
        if (n > 0) begin
            if (r == 32) r = 0;
            tmp = 0; sh = 24;
            while (n > 0) begin
                if (st) exp_mem[a % 256] = 8'(exp_rf[r] >> sh);
                else tmp = tmp | (32'(exp_mem[a % 256]) << sh);
                sh -= 8; a++; n--;
            end
            if (!st) exp_rf[r] = tmp;
        end
    endtask

    task automatic run_op(input bit st, input bit sm, input int sreg, input int cnt,
                          input int base, input bit poke, input string tag);
        int cyc, req0;
        model(st, sm, sreg, cnt, base);
        req0 = req_cycles;
        @(negedge clk);
        xfer_store_i = st; xfer_string_i = sm; first_reg_i = 5'(sreg);
        byte_cnt_i = CNT_W'(cnt); base_addr_i = ADDR_W'(base); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; cyc = 1;
        while (!done_o && cyc < 4000) begin
            if (poke && cyc == 3) begin
                start_i = 1'b1; xfer_store_i = ~st; first_reg_i = 5'd2;
                byte_cnt_i = 8'd9; base_addr_i = 32'h10;
            end else start_i = 1'b0;
            @(negedge clk); cyc++;
        end
        check(done_o, {tag, " done seen"}, done_o, 1);
        if (poke) begin
            start_i = 1'b1; xfer_string_i = 1'b1; byte_cnt_i = 8'd4;  // in done cycle (R10)
        end
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o, "R11 done single pulse", done_o, 0);
        if (poke) check(!busy_o && !mem_req_o, "R10 start in done cycle ignored", busy_o, 0);
        if (sm && cnt == 0) begin
            check(cyc == 1, "R8 done next cycle", cyc, 1);
            check(req_cycles == req0, "R8 no request", req_cycles - req0, 0);
        end
        for (int r = 0; r < 32; r++) check(rf[r] == exp_rf[r], tag, rf[r], exp_rf[r]);
        for (int i = 0; i < 256; i++) check(mem[i] == exp_mem[i], tag, mem[i], exp_mem[i]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        preload(0);
        repeat (3) @(negedge clk);
        check(!busy_o && !mem_req_o && !done_o && !rf_we_o, "R1 reset outputs", busy_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !mem_req_o && !done_o && !rf_we_o, "R1 after reset", mem_req_o, 0);

        preload(1); run_op(0, 0, 28, 3, 32'h20, 0, "R2 multi load");
        preload(2); run_op(0, 0, 0, 0, 32'h40, 0, "R2 multi load all");
        preload(3); run_op(1, 0, 29, 0, 32'h13, 0, "R3 multi store");
        preload(4); run_op(1, 0, 31, 50, 32'h80, 0, "R3 multi store one");
        preload(5); run_op(0, 1, 30, 40, 32'h08, 0, "R4 R5 string load wrap");
        preload(6); run_op(1, 1, 30, 37, 32'h31, 0, "R5 R7 string store wrap");
        preload(7); run_op(0, 1, 31, 39, 32'h05, 0, "R6 load tail three");
        preload(8); run_op(0, 1, 12, 1, 32'h07, 0, "R6 load tail one");
        preload(9); run_op(1, 1, 31, 2, 32'h61, 0, "R7 store tail two");
        preload(10); run_op(0, 1, 4, 0, 32'h00, 0, "R8 zero count");
        preload(11); run_op(0, 1, 29, 22, 32'h44, 1, "R10 start while busy");
        for (int c = 0; c <= 40; c++) begin
            preload(12 + c); run_op(0, 1, 25 + (c % 7), c, 3 * c, 0, "R6 sweep load");
            preload(60 + c); run_op(1, 1, 31 - (c % 5), c, 2 * c + 1, 0, "R7 sweep store");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule